// File: doc/BRIEF.md
# Block String Operation Engine

This engine carries out one block string instruction at a time on a byte-wide memory port with a one-cycle read latency. The instruction comes with three working registers. The first is a destination or scan pointer. The second is either a source pointer or a compare or fill value. The third is an element count. A pulse on `start` loads these registers together with an operation code and an element size. The engine then steps through memory one element at a time until the operation's stop rule is met.

When it stops, it returns the updated registers and a zero flag and a carry flag. A single-cycle `done` marks the cycle in which these results are valid.

There are seven operations:

- forward copy
- backward copy
- copy up to and including a zero byte
- fill
- scan until equal
- scan while equal
- byte-string compare

Each operation has its own stop rule and its own way of deriving the flags. Memory is accessed one byte at a time. Halfword and word elements are split into bytes in little-endian order.

Top module: `strop_engine`

## Requirements
- R1: After reset the engine is idle. `busy`, `done`, `size_err`, `zf` and `cf` are 0, and no memory read or write is issued while idle.
- R2: Each element moved or examined lowers the count by exactly one, and every operation ends when the count reaches zero. `busy` stays high from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle, the cycle after the last register update.
- R3: Forward copy (op 0) reads the byte at the source pointer, writes it at the destination pointer, and adds 1 to both pointers. Copy operations leave `zf` and `cf` unchanged.
- R4: Backward copy (op 1) moves one byte per element as op 0 does, but subtracts 1 from both pointers.
- R5: Copy-to-zero (op 2) behaves like op 0, except that it stops right after it has copied a zero byte.
- R6: Fill (op 3) writes the low 1, 2 or 4 bytes of the value register at the destination pointer, least significant byte at the lowest address. It then advances that pointer by the element size. No memory reads are made.
- R7: Scan-until (op 4) reads an element at the scan pointer, zero-extended and little-endian, and advances the pointer by the element size. It stops when the element equals the whole 32-bit value register. `zf` = the last element equalled the value; `cf` = the last element <= the value, compared unsigned.
- R8: Scan-while (op 5) stops when an element differs from the value. `zf` = the remaining count is zero; `cf` = the last element <= the value, compared unsigned.
- R9: Compare (op 6) reads one byte at the first pointer and one at the second, adding 1 to each pointer. It stops on a mismatch or when the first byte is zero. `zf` = the last two bytes are equal; `cf` = first byte >= second byte.
- R10: A start with a count of zero makes no memory access. It returns all three registers unchanged, leaves `zf` and `cf` unchanged, and raises `done` on the next cycle.
- R11: Element size codes are 0 = byte, 1 = halfword and 2 = word, used by ops 3 to 5. For those ops, size code 3 and op code 7 are illegal. An illegal request sets `size_err` with `done` on the next cycle, makes no memory access, and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op | input | 3 | Operation code (see R3-R9 for each code) |
| esize | input | 2 | Element size code |
| r1_in | input | 32 | Initial destination / scan pointer |
| r2_in | input | 32 | Initial source pointer or value |
| r3_in | input | 32 | Initial element count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| size_err | output | 1 | Illegal request flag, valid with done |
| r1_out | output | 32 | Current pointer register 1 |
| r2_out | output | 32 | Current pointer / value register 2 |
| r3_out | output | 32 | Current count |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry flag |
| mem_rd | output | 1 | Byte read request |
| mem_wr | output | 1 | Byte write request |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write data byte |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |

## Verification
The time an operation takes depends on the data. Each copied element takes four cycles, and each byte read takes two cycles. So the bench never counts a fixed latency. After releasing `start`, it samples on every falling edge until `done` is seen. At that one sampling point it reads the registers, the flags and `size_err`. It then confirms that `done` has dropped on the next falling edge. Memory effects are checked in the bench's own byte array after `done`. The bench also counts memory accesses across each operation, which shows that zero-count and illegal requests make none.

// File: rtl/strop_pkg.sv
package strop_pkg;
  typedef enum logic [2:0] {
    OP_CPY_FWD  = 3'd0,
    OP_CPY_BWD  = 3'd1,
    OP_CPY_ZT   = 3'd2,
    OP_FILL     = 3'd3,
    OP_SCAN_EQ  = 3'd4,
    OP_SCAN_NE  = 3'd5,
    OP_CMP      = 3'd6,
    OP_RSVD     = 3'd7
  } strop_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_CAP, S_WR, S_UPD, S_FIN
  } strop_st_e;

  function automatic logic op_sized(strop_op_e o);
    return (o == OP_FILL) || (o == OP_SCAN_EQ) || (o == OP_SCAN_NE);
  endfunction

  function automatic logic op_copy(strop_op_e o);
    return (o == OP_CPY_FWD) || (o == OP_CPY_BWD) || (o == OP_CPY_ZT);
  endfunction
endpackage

// File: rtl/strop_addr_gen.sv
module strop_addr_gen
  import strop_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int KW = $clog2(XLEN / 8)
) (
  input  strop_op_e        op,
  input  logic [XLEN-1:0]  ptr_a,
  input  logic [XLEN-1:0]  ptr_b,
  input  logic [KW-1:0]    lane,
  input  logic             side_b,
  input  logic [7:0]       copy_byte,
  output logic [XLEN-1:0]  rd_addr,
  output logic [XLEN-1:0]  wr_addr,
  output logic [7:0]       wr_byte
);
  logic [XLEN-1:0] rd_base;
  logic [XLEN-1:0] lane_off;

  assign lane_off = XLEN'(lane);

  always_comb begin
    if (op_copy(op) || (op == OP_CMP && side_b)) rd_base = ptr_b;
    else                                         rd_base = ptr_a;
  end

  assign rd_addr = rd_base + lane_off;
  assign wr_addr = ptr_a + lane_off;
  assign wr_byte = (op == OP_FILL) ? ptr_b[lane*8 +: 8] : copy_byte;
endmodule

// File: rtl/strop_stop_eval.sv
module strop_stop_eval
  import strop_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  strop_op_e       op,
  input  logic [XLEN-1:0] elem,
  input  logic [7:0]      other_byte,
  input  logic [XLEN-1:0] value,
  input  logic [XLEN-1:0] count_next,
  output logic            stop,
  output logic            z_new,
  output logic            c_new
);
  logic cnt_end, eq_val, le_val;
  logic [7:0] lo;

  assign lo      = elem[7:0];
  assign cnt_end = (count_next == '0);
  assign eq_val  = (elem == value);
  assign le_val  = (elem <= value);

  always_comb begin
    stop  = cnt_end;
    z_new = 1'b0;
    c_new = 1'b0;
    unique case (op)
      OP_CPY_ZT:  stop = cnt_end || (lo == 8'h00);
      OP_SCAN_EQ: begin
        stop  = cnt_end || eq_val;
        z_new = eq_val;
        c_new = le_val;
      end
      OP_SCAN_NE: begin
        stop  = cnt_end || !eq_val;
        z_new = cnt_end;
        c_new = le_val;
      end
      OP_CMP: begin
        stop  = cnt_end || (lo != other_byte) || (lo == 8'h00);
        z_new = (lo == other_byte);
        c_new = (lo >= other_byte);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/strop_engine.sv
module strop_engine
  import strop_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int KW = $clog2(XLEN / 8)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [1:0]      esize,
  input  logic [XLEN-1:0] r1_in,
  input  logic [XLEN-1:0] r2_in,
  input  logic [XLEN-1:0] r3_in,
  output logic            busy,
  output logic            done,
  output logic            size_err,
  output logic [XLEN-1:0] r1_out,
  output logic [XLEN-1:0] r2_out,
  output logic [XLEN-1:0] r3_out,
  output logic            zf,
  output logic            cf,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [XLEN-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata
);
  strop_st_e       st;
  strop_op_e       op_q, op_in;
  logic [XLEN-1:0] r1, r2, r3, va;
  logic [7:0]      vb;
  logic [KW-1:0]   lane, last_lane;
  logic            side_b;
  logic            zf_q, cf_q, err_q;
  logic [XLEN-1:0] rd_addr, wr_addr, r3_next, step;
  logic [7:0]      wr_byte;
  logic            stop, z_new, c_new, bad_req;

  assign op_in   = strop_op_e'(op);
  assign bad_req = (op_in == OP_RSVD) || (op_sized(op_in) && esize == 2'd3);
  assign r3_next = r3 - XLEN'(1);
  assign step    = XLEN'(last_lane) + XLEN'(1);

  strop_addr_gen #(.XLEN(XLEN)) u_addr (
    .op(op_q), .ptr_a(r1), .ptr_b(r2), .lane(lane), .side_b(side_b),
    .copy_byte(va[7:0]), .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_byte(wr_byte)
  );

  strop_stop_eval #(.XLEN(XLEN)) u_eval (
    .op(op_q), .elem(va), .other_byte(vb), .value(r2), .count_next(r3_next),
    .stop(stop), .z_new(z_new), .c_new(c_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; op_q <= OP_CPY_FWD;
      r1 <= '0; r2 <= '0; r3 <= '0; va <= '0; vb <= '0;
      lane <= '0; last_lane <= '0; side_b <= 1'b0;
      zf_q <= 1'b0; cf_q <= 1'b0; err_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          op_q <= op_in; r1 <= r1_in; r2 <= r2_in; r3 <= r3_in;
          va <= '0; lane <= '0; side_b <= 1'b0; err_q <= bad_req;
          last_lane <= op_sized(op_in) ? KW'((1 << esize) - 1) : '0;
          if (bad_req || r3_in == '0) st <= S_FIN;
          else if (op_in == OP_FILL)  st <= S_WR;
          else                        st <= S_RD;
        end
        S_RD: st <= S_CAP;
        S_CAP: begin
          if (op_copy(op_q)) begin
            va[7:0] <= mem_rdata;
            st <= S_WR;
          end else if (op_q == OP_CMP) begin
            if (!side_b) begin
              va[7:0] <= mem_rdata; side_b <= 1'b1; st <= S_RD;
            end else begin
              vb <= mem_rdata; st <= S_UPD;
            end
          end else begin
            va[lane*8 +: 8] <= mem_rdata;
            if (lane == last_lane) st <= S_UPD;
            else begin lane <= lane + 1'b1; st <= S_RD; end
          end
        end
        S_WR: begin
          if (op_q == OP_FILL && lane != last_lane) lane <= lane + 1'b1;
          else st <= S_UPD;
        end
        S_UPD: begin
          unique case (op_q)
            OP_CPY_BWD: begin r1 <= r1 - XLEN'(1); r2 <= r2 - XLEN'(1); end
            OP_FILL, OP_SCAN_EQ, OP_SCAN_NE: r1 <= r1 + step;
            default:    begin r1 <= r1 + XLEN'(1); r2 <= r2 + XLEN'(1); end
          endcase
          r3 <= r3_next;
          if (!op_copy(op_q) && op_q != OP_FILL) begin
            zf_q <= z_new; cf_q <= c_new;
          end
          lane <= '0; side_b <= 1'b0;
          if (stop) st <= S_FIN;
          else begin
            va <= '0;
            st <= (op_q == OP_FILL) ? S_WR : S_RD;
          end
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign size_err  = err_q;
  assign r1_out    = r1;
  assign r2_out    = r2;
  assign r3_out    = r3;
  assign zf        = zf_q;
  assign cf        = cf_q;
  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? wr_addr : rd_addr;
  assign mem_wdata = wr_byte;

  // R1: no memory traffic while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd && !mem_wr));
  // R2: each element update lowers the count by one
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_UPD) |=> (r3 == $past(r3) - XLEN'(1)));
  // R2: done lasts a single cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: fill never reads
  p_fill_no_read_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && op_q == OP_FILL) |-> !mem_rd);
  // R10: zero count leaves flags alone and touches no memory
  p_zero_count_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start && r3_in == '0) |=>
      ($stable(zf) && $stable(cf) && done && !mem_rd && !mem_wr));
  // R11: illegal request ends at once with the error flag
  p_bad_size_r11: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start && bad_req) |=> (done && size_err));
endmodule

// File: tb/tb_strop_engine.sv
`timescale 1ns/1ps
module tb_strop_engine;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] esize = '0;
  logic [31:0] r1_in = '0, r2_in = '0, r3_in = '0;
  logic busy, done, size_err, zf, cf, mem_rd, mem_wr;
  logic [31:0] r1_out, r2_out, r3_out, mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] mem [256];
  int acc_cnt = 0;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  strop_engine dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .esize(esize),
    .r1_in(r1_in), .r2_in(r2_in), .r3_in(r3_in), .busy(busy), .done(done),
    .size_err(size_err), .r1_out(r1_out), .r2_out(r2_out), .r3_out(r3_out),
    .zf(zf), .cf(cf), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] = mem_wdata;
    if (mem_rd || mem_wr) acc_cnt <= acc_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [1:0] s,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    int guard;
    @(negedge clk);
    op = o; esize = s; r1_in = a; r2_in = b; r3_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", {31'b0, busy || done}, 32'd1);
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk("R2 done seen", {31'b0, done}, 32'd1);
  endtask

  task automatic done_drops();
    @(negedge clk);
    chk("R2 done one cycle", {31'b0, done}, 32'd0);
  endtask

  typedef struct packed {
    logic [2:0] o; logic [1:0] s;
    logic [31:0] a, b, c, ea, eb, ec;
    logic ez, ecf;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{3'd4, 2'd0, 32'h10, 32'h43, 32'd5, 32'h13, 32'h43, 32'd2, 1'b1, 1'b1},
    '{3'd4, 2'd0, 32'h10, 32'h99, 32'd3, 32'h13, 32'h99, 32'd0, 1'b0, 1'b1},
    '{3'd5, 2'd1, 32'h40, 32'h05, 32'd4, 32'h46, 32'h05, 32'd1, 1'b0, 1'b0},
    '{3'd5, 2'd1, 32'h40, 32'h05, 32'd2, 32'h44, 32'h05, 32'd0, 1'b1, 1'b1},
    '{3'd4, 2'd2, 32'h50, 32'h10, 32'd4, 32'h58, 32'h10, 32'd2, 1'b1, 1'b1},
    '{3'd6, 2'd0, 32'h10, 32'h30, 32'd8, 32'h14, 32'h34, 32'd4, 1'b1, 1'b1},
    '{3'd6, 2'd0, 32'h10, 32'h20, 32'd8, 32'h13, 32'h23, 32'd5, 1'b0, 1'b0},
    '{3'd6, 2'd0, 32'h20, 32'h10, 32'd2, 32'h22, 32'h12, 32'd0, 1'b1, 1'b1}
  };

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int snap;
    string tag;
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    mem[8'h10] = 8'h41; mem[8'h11] = 8'h42; mem[8'h12] = 8'h43; mem[8'h13] = 8'h00; mem[8'h14] = 8'h44;
    mem[8'h20] = 8'h41; mem[8'h21] = 8'h42; mem[8'h22] = 8'h44; mem[8'h23] = 8'h00;
    mem[8'h30] = 8'h41; mem[8'h31] = 8'h42; mem[8'h32] = 8'h43; mem[8'h33] = 8'h00;
    mem[8'h40] = 8'h05; mem[8'h41] = 8'h00; mem[8'h42] = 8'h05; mem[8'h43] = 8'h00;
    mem[8'h44] = 8'h07; mem[8'h45] = 8'h00; mem[8'h46] = 8'h09; mem[8'h47] = 8'h00;
    mem[8'h50] = 8'h44; mem[8'h51] = 8'h33; mem[8'h52] = 8'h22; mem[8'h53] = 8'h11;
    mem[8'h54] = 8'h10; mem[8'h55] = 8'h00; mem[8'h56] = 8'h00; mem[8'h57] = 8'h00;

    repeat (3) @(negedge clk);
    // R1 reset state
    snap = acc_cnt;
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 flags", {30'b0, zf, cf}, 32'd0);
    chk("R1 err", {31'b0, size_err}, 32'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 no access idle", acc_cnt - snap, 32'd0);

    // table: scans and compares (R7 R8 R9)
    for (int i = 0; i < 8; i++) begin
      tag = (VT[i].o == 3'd4) ? "R7" : (VT[i].o == 3'd5) ? "R8" : "R9";
      run_op(VT[i].o, VT[i].s, VT[i].a, VT[i].b, VT[i].c);
      chk($sformatf("%s vec%0d r1", tag, i), r1_out, VT[i].ea);
      chk($sformatf("%s vec%0d r2", tag, i), r2_out, VT[i].eb);
      chk($sformatf("%s vec%0d r3 (R2 count)", tag, i), r3_out, VT[i].ec);
      chk($sformatf("%s vec%0d z", tag, i), {31'b0, zf}, {31'b0, VT[i].ez});
      chk($sformatf("%s vec%0d c", tag, i), {31'b0, cf}, {31'b0, VT[i].ecf});
      done_drops();
    end

    // R3 forward copy; flags stay 1/1 from last vector
    run_op(3'd0, 2'd0, 32'h80, 32'h10, 32'd4);
    chk("R3 r1", r1_out, 32'h84);
    chk("R3 r2", r2_out, 32'h14);
    chk("R3 r3", r3_out, 32'd0);
    chk("R3 flags unchanged", {30'b0, zf, cf}, 32'd3);
    chk("R3 data", {mem[8'h80], mem[8'h81], mem[8'h82], mem[8'h83]}, 32'h41424300);
    done_drops();

    // R4 backward copy
    run_op(3'd1, 2'd0, 32'h9F, 32'h13, 32'd3);
    chk("R4 r1", r1_out, 32'h9C);
    chk("R4 r2", r2_out, 32'h10);
    chk("R4 r3", r3_out, 32'd0);
    chk("R4 data", {8'h0, mem[8'h9D], mem[8'h9E], mem[8'h9F]}, 32'h00424300);
    chk("R4 below untouched", {24'b0, mem[8'h9C]}, 32'hEE);

    // R5 copy to zero
    run_op(3'd2, 2'd0, 32'hA0, 32'h10, 32'd10);
    chk("R5 r1", r1_out, 32'hA4);
    chk("R5 r2", r2_out, 32'h14);
    chk("R5 r3", r3_out, 32'd6);
    chk("R5 data", {mem[8'hA0], mem[8'hA1], mem[8'hA2], mem[8'hA3]}, 32'h41424300);
    chk("R5 stop after zero", {24'b0, mem[8'hA4]}, 32'hEE);

    // R6 fill word and halfword
    snap = acc_cnt;
    run_op(3'd3, 2'd2, 32'hB0, 32'hCAFEBABE, 32'd2);
    chk("R6 word r1", r1_out, 32'hB8);
    chk("R6 word r2", r2_out, 32'hCAFEBABE);
    chk("R6 word r3", r3_out, 32'd0);
    chk("R6 word lo", {mem[8'hB3], mem[8'hB2], mem[8'hB1], mem[8'hB0]}, 32'hCAFEBABE);
    chk("R6 word hi", {mem[8'hB7], mem[8'hB6], mem[8'hB5], mem[8'hB4]}, 32'hCAFEBABE);
    chk("R6 word end", {24'b0, mem[8'hB8]}, 32'hEE);
    chk("R6 access count", acc_cnt - snap, 32'd8);
    run_op(3'd3, 2'd1, 32'hC0, 32'h00001234, 32'd1);
    chk("R6 half r1", r1_out, 32'hC2);
    chk("R6 half data", {8'h0, mem[8'hC2], mem[8'hC1], mem[8'hC0]}, 32'h00EE1234);

    // R10 zero count: flags 1/1 held, no access, regs returned
    snap = acc_cnt;
    run_op(3'd4, 2'd0, 32'h10, 32'h41, 32'd0);
    chk("R10 r1", r1_out, 32'h10);
    chk("R10 r3", r3_out, 32'd0);
    chk("R10 flags", {30'b0, zf, cf}, 32'd3);
    chk("R10 no access", acc_cnt - snap, 32'd0);
    done_drops();
    run_op(3'd6, 2'd0, 32'h10, 32'h20, 32'd0);
    chk("R10 cmp flags", {30'b0, zf, cf}, 32'd3);
    chk("R10 cmp no access", acc_cnt - snap, 32'd0);

    // R11 illegal size and op
    snap = acc_cnt;
    run_op(3'd3, 2'd3, 32'hD0, 32'h55, 32'd4);
    chk("R11 err", {31'b0, size_err}, 32'd1);
    chk("R11 r1", r1_out, 32'hD0);
    chk("R11 r3", r3_out, 32'd4);
    chk("R11 mem", {24'b0, mem[8'hD0]}, 32'hEE);
    chk("R11 no access", acc_cnt - snap, 32'd0);
    run_op(3'd7, 2'd0, 32'hD0, 32'h55, 32'd4);
    chk("R11 op7 err", {31'b0, size_err}, 32'd1);
    run_op(3'd0, 2'd3, 32'hE0, 32'h10, 32'd1);
    chk("R11 copy ignores size", {31'b0, size_err}, 32'd0);
    chk("R11 copy data", {24'b0, mem[8'hE0]}, 32'h41);

    // R1 back to idle
    @(negedge clk);
    chk("R1 idle after op", {31'b0, busy}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule